// File: doc/BRIEF.md
# Fractional Clock Enable Generator

This block derives a single-cycle enable strobe from a fast free-running clock, so that the strobe's long-run rate is a rational fraction NUM/DEN of the clock rate. With the default NUM = 83 and DEN = 125, a 50 MHz clock yields an average strobe rate of 33.2 MHz. Logic downstream stays in the fast clock domain and advances only on cycles where the strobe is high. No second clock domain is created.

The fraction is produced by a phase accumulator. On every active cycle the accumulator adds NUM. When the sum reaches DEN, it subtracts DEN and fires the strobe. This spreads the strobes as evenly as the ratio allows, rather than bunching them into one burst per period. A `run` input pauses the sequence without losing its phase. A synchronous reset restarts the sequence from phase zero. When NUM equals DEN, an elaboration-time variant removes the accumulator and passes `run` straight to the output register.

Top module: `frac_clk_en`

## Requirements
- R1: While `rst` is high at a rising edge, the phase is cleared to zero and `ce` reads 0 after that edge.
- R2: Counting only the edges where `run` is 1 and `rst` is 0 (running edges), `ce` after the k-th running edge since reset equals floor(k*NUM/DEN) - floor((k-1)*NUM/DEN). Here `ce` = 1 means a strobe.
- R3: Immediately after the k-th running edge since reset, the total number of strobes seen since reset equals floor(k*NUM/DEN).
- R4: Every block of DEN consecutive running edges, counted from reset, carries exactly NUM strobes.
- R5: Between two strobes there are at most ceil(DEN/NUM)-1 running edges without a strobe. For the default 83/125 ratio, consecutive strobes are therefore 1 or 2 running edges apart.
- R6: An edge with `run` = 0 leaves `ce` at 0 and keeps the phase, so the sequence resumes exactly where it paused.
- R7: When NUM = DEN, `ce` is 1 after every running edge and 0 otherwise.
- R8: Parameters outside 0 < NUM <= DEN stop elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Advance the phase on this edge when 1; hold it when 0 |
| ce | output | 1 | Registered enable strobe, high for one clock per strobe |

## Verification
The phase register is never visible at the ports. A wrong phase therefore appears only as a strobe that fires one running edge too early or too late. This is caught at the first such edge, because every cycle is compared against the closed-form floor(k*NUM/DEN) pattern. A phase that drifts shows up in two further ways: the per-block strobe count is off at the next DEN boundary, and the cumulative strobe count is off at the next sampling point. A phase lost during a pause shows up on the first running edge after `run` returns.

// File: rtl/frac_ce_pkg.sv
package frac_ce_pkg;

   // Width able to hold every value up to n + d - 1.
   function automatic int phase_width(input int n, input int d);
      int w;
      w = $clog2(n + d);
      return (w < 1) ? 1 : w;
   endfunction

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

endpackage

// File: rtl/frac_ce_accum.sv
module frac_ce_accum
   import frac_ce_pkg::*;
#(
   parameter int NUM = 83,
   parameter int DEN = 125,
   parameter int W   = phase_width(NUM, DEN)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         run,
   output logic [W-1:0] phase,
   output logic         wrap
);

   localparam logic [W-1:0] STEP = W'(NUM);
   localparam logic [W-1:0] MODV = W'(DEN);

   logic [W-1:0] phase_q;
   logic [W-1:0] sum;

   always_comb begin
      sum  = phase_q + STEP;
      wrap = (sum >= MODV);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= '0;
      end else if (run) begin
         if (wrap) phase_q <= sum - MODV;
         else      phase_q <= sum;
      end
   end

   assign phase = phase_q;

   // R2: phase stays a residue modulo DEN
   a_r2_phase_residue: assert property (@(posedge clk) disable iff (rst)
      phase_q < MODV);

   // R6: a paused edge keeps the phase
   a_r6_phase_hold: assert property (@(posedge clk) disable iff (rst)
      !run |=> $stable(phase_q));

   // R1: reset clears the phase
   a_r1_phase_clear: assert property (@(posedge clk)
      rst |=> phase_q == '0);

endmodule

// File: rtl/frac_ce_outreg.sv
module frac_ce_outreg (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic wrap,
   output logic ce
);

   logic ce_q;

   always_ff @(posedge clk) begin
      if (rst) ce_q <= 1'b0;
      else     ce_q <= run & wrap;
   end

   assign ce = ce_q;

   // R6: no strobe after a paused edge
   a_r6_quiet_pause: assert property (@(posedge clk) disable iff (rst)
      !run |=> !ce_q);

   // R1: strobe low after reset
   a_r1_ce_low: assert property (@(posedge clk)
      rst |=> !ce_q);

endmodule

// File: rtl/frac_clk_en.sv
module frac_clk_en
   import frac_ce_pkg::*;
#(
   parameter int NUM = 83,
   parameter int DEN = 125
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic ce
);

   localparam int W        = phase_width(NUM, DEN);
   localparam int MAX_IDLE = ceil_div(DEN, NUM) - 1;

   // R8: elaboration-time parameter check
   if (NUM < 1 || NUM > DEN) begin : g_bad_ratio
      $error("frac_clk_en: NUM must satisfy 0 < NUM <= DEN");
   end

   if (NUM == DEN) begin : g_full
      frac_ce_outreg u_out (
         .clk  (clk),
         .rst  (rst),
         .run  (run),
         .wrap (1'b1),
         .ce   (ce)
      );

      // R7: full rate follows run by one edge
      a_r7_full_rate: assert property (@(posedge clk) disable iff (rst)
         run |=> ce);
   end else begin : g_frac
      logic [W-1:0] phase;
      logic         wrap;

      frac_ce_accum #(.NUM(NUM), .DEN(DEN), .W(W)) u_acc (
         .clk   (clk),
         .rst   (rst),
         .run   (run),
         .phase (phase),
         .wrap  (wrap)
      );

      frac_ce_outreg u_out (
         .clk  (clk),
         .rst  (rst),
         .run  (run),
         .wrap (wrap),
         .ce   (ce)
      );

      // Observation counters for the window and spacing properties
      localparam logic [W-1:0] LAST_CYC = W'(DEN - 1);
      localparam logic [W-1:0] NUM_W    = W'(NUM);
      localparam logic [W-1:0] IDLE_W   = W'(MAX_IDLE);

      logic         prev_run;
      logic [W-1:0] win_cyc;
      logic [W-1:0] win_pul;
      logic [W-1:0] idle_cnt;

      always_ff @(posedge clk) begin
         if (rst) begin
            prev_run <= 1'b0;
            win_cyc  <= '0;
            win_pul  <= '0;
            idle_cnt <= '0;
         end else begin
            prev_run <= run;
            if (prev_run) begin
               if (win_cyc == LAST_CYC) begin
                  win_cyc <= '0;
                  win_pul <= '0;
               end else begin
                  win_cyc <= win_cyc + 1'b1;
                  win_pul <= win_pul + W'(ce);
               end
               if (ce) idle_cnt <= '0;
               else    idle_cnt <= idle_cnt + 1'b1;
            end
         end
      end

      // R4: exactly NUM strobes per block of DEN running edges
      a_r4_window_count: assert property (@(posedge clk) disable iff (rst)
         (prev_run && win_cyc == LAST_CYC) |-> (win_pul + W'(ce)) == NUM_W);

      // R5: bounded spacing between strobes
      a_r5_gap_bound: assert property (@(posedge clk) disable iff (rst)
         (prev_run && !ce) |-> idle_cnt < IDLE_W + 1'b1);

      // R2: a wrap on a running edge produces a strobe
      a_r2_wrap_strobe: assert property (@(posedge clk) disable iff (rst)
         (run && wrap) |=> ce);
   end

endmodule

// File: tb/sim_frac_clk_en.sv
module sim_frac_clk_en;

   localparam int CLK_PERIOD = 20;
   localparam int N0 = 83;
   localparam int D0 = 125;
   localparam int N1 = 5;

   typedef struct {
      bit    exp0;
      bit    exp1;
      bit    ran;
      bit    was_rst;
      int    k;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic run = 1'b0;
   logic ce0, ce1;

   int checks = 0;
   int errors = 0;
   int k = 0;
   item_t q[$];

   // monitor state
   int wc = 0, wp = 0, idle = 0, cum = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_clk_en #(.NUM(N0), .DEN(D0)) u0 (.clk(clk), .rst(rst), .run(run), .ce(ce0));
   frac_clk_en #(.NUM(N1), .DEN(N1)) u1 (.clk(clk), .rst(rst), .run(run), .ce(ce1));

   function automatic int fl(input int kk, input int n, input int d);
      return (kk * n) / d;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: set inputs at the falling edge and queue the expectation
   task automatic drive(input bit r, input bit rn, input string tag);
      item_t it;
      @(negedge clk);
      rst = r;
      run = rn;
      it.tag = tag;
      it.was_rst = r;
      it.ran = !r && rn;
      if (r) begin
         k = 0;
         it.exp0 = 1'b0;
         it.exp1 = 1'b0;
      end else if (rn) begin
         k++;
         it.exp0 = (fl(k, N0, D0) - fl(k - 1, N0, D0)) != 0;
         it.exp1 = 1'b1;
      end else begin
         it.exp0 = 1'b0;
         it.exp1 = 1'b0;
      end
      it.k = k;
      q.push_back(it);
   endtask

   // monitor: compare just after the edge that registers the result
   initial begin
      forever begin
         item_t it;
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            it = q.pop_front();
            check({it.tag, " ce0"}, ce0, it.exp0);
            check({it.tag, " ce1 R7"}, ce1, it.exp1);
            if (it.was_rst) begin
               wc = 0; wp = 0; idle = 0; cum = 0;
            end else if (it.ran) begin
               wc++;
               wp += ce0;
               cum += ce0;
               if (ce0) begin
                  check("R5 gap", idle <= (D0 + N0 - 1) / N0 - 1, 1);
                  idle = 0;
               end else begin
                  idle++;
               end
               if (wc == D0) begin
                  check("R4 window", wp, N0);
                  wc = 0;
                  wp = 0;
               end
               if (it.k % 37 == 0) check("R3 cumulative", cum, fl(it.k, N0, D0));
            end
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, "R1");
      // R2/R4/R5: continuous running over many windows
      for (int i = 0; i < D0 * 12; i++) drive(1'b0, 1'b1, "R2");
      // R6: pauses of varying length inside the sequence
      for (int p = 1; p < 8; p++) begin
         for (int i = 0; i < p; i++) drive(1'b0, 1'b0, "R6");
         for (int i = 0; i < 3 * p + 5; i++) drive(1'b0, 1'b1, "R6 resume");
      end
      // R6: alternating run pattern
      for (int i = 0; i < D0 * 4; i++) drive(1'b0, (i % 3) != 0, "R6 alt");
      // R1: reset in the middle of a sequence, then restart from phase zero
      for (int i = 0; i < 2; i++) drive(1'b1, 1'b1, "R1 mid");
      for (int i = 0; i < D0 * 8; i++) drive(1'b0, 1'b1, "R2 restart");
      drive(1'b0, 1'b0, "R6");
      drive(1'b0, 1'b0, "R6");
      @(posedge clk);
      @(posedge clk);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule